// File: doc/BRIEF.md
# Odd-Ratio Half-Duty Clock Divider

This block takes a reference clock and produces a slower clock whose period is an odd whole number of reference periods (3, 5, 7 and so on). The output is high for exactly half of each of its own periods. A counter alone cannot give this result, because an odd count splits into two unequal whole-cycle halves. The block therefore places one of its output edges on a falling edge of the reference.

Internally a modulo-N count runs on the rising reference edge. Two toggle flops each run at half the output rate. One toggles on a rising edge when the count is zero. The other toggles on a falling edge when the count equals the integer half of N plus one. The two toggles are a quarter of their own period apart, so at most one of them changes at any instant. Their exclusive-OR is the output, and it is free of glitches. The output duty is exactly one half only when the reference duty is one half.

The ratio is fixed when the design is built. An even ratio, or a ratio below 3, stops elaboration. An active-low asynchronous reset clears all state and holds the output low.

Top module: `odd_clk_div`

## Requirements
- R1: While rst_ni is low, clk_o is 0. Asserting rst_ni at any moment, including between reference edges, forces clk_o to 0 without waiting for a clock edge.
- R2: After rst_ni is released between reference edges, the first change of clk_o is a rise to 1 at the first rising edge of clk_i after the release.
- R3: From the first rise onward, successive rising edges of clk_o are exactly DIV_N reference periods apart.
- R4: Each high phase of clk_o lasts exactly DIV_N reference half-periods.
- R5: Each low phase of clk_o after the first rise lasts exactly DIV_N reference half-periods.
- R6: clk_o changes only on reference edges. It rises only on a rising edge of clk_i and falls only on a falling edge of clk_i.
- R7: The internal count steps 0,1,…,DIV_N-1 and then wraps to 0 on rising edges. The rising-edge toggle flips only when the count is 0. The falling-edge toggle flips only when the count is DIV_N/2+1 (integer division).
- R8: A reset applied in mid-run, with clk_o high or low, and then released again restarts the output with the same timing as required by R2 through R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock; its duty cycle should be 50% |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_o | output | 1 | Divided clock, period DIV_N reference periods, 50% duty |

## Verification
The two events most likely to collide are the counter wrap and the falling-edge toggle's trigger. With DIV_N = 3 the falling-edge match value, 2, is also the terminal count, so in one reference cycle the counter wraps after the falling toggle has fired on the preceding low phase. The bench runs instances with DIV_N = 3, 5 and 7 side by side, and the DIV_N = 3 instance makes this overlap occur every output period. It judges every output edge against a scoreboard of expected edge times and levels, and against the measured high and low intervals. It also applies a mid-run reset off the clock edge and checks that the output restarts cleanly.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  function automatic int cnt_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // count value at which the falling-edge toggle flips
  function automatic int fall_match(input int n);
    return n / 2 + 1;
  endfunction

endpackage

// File: rtl/clkdiv_mod_counter.sv
module clkdiv_mod_counter #(
  parameter  int MODULUS = 3,
  localparam int W       = clkdiv_pkg::cnt_bits(MODULUS)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] LAST = W'(MODULUS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= '0;
    else if (cnt_o == LAST) cnt_o <= '0;
    else                    cnt_o <= cnt_o + 1'b1;
  end

  p_cnt_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == LAST) |=> (cnt_o == '0));

  p_cnt_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o != LAST) |=> (cnt_o == $past(cnt_o) + 1'b1));

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o <= LAST));

endmodule

// File: rtl/clkdiv_edge_toggle.sv
module clkdiv_edge_toggle #(
  parameter bit RISING = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic q_o
);

  if (RISING) begin : g_rise
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_o <= 1'b0;
      else if (en_i) q_o <= ~q_o;
    end
  end else begin : g_fall
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_o <= 1'b0;
      else if (en_i) q_o <= ~q_o;
    end
  end

endmodule

// File: rtl/odd_clk_div.sv
module odd_clk_div #(
  parameter int DIV_N = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic clk_o
);

  localparam int           W    = clkdiv_pkg::cnt_bits(DIV_N);
  localparam logic [W-1:0] MID  = W'(clkdiv_pkg::fall_match(DIV_N));

  if (DIV_N < 3 || (DIV_N % 2) == 0) begin : g_bad_ratio
    $error("odd_clk_div: DIV_N must be odd and at least 3");
  end

  logic [W-1:0] cnt;
  logic         rise_en, fall_en;
  logic         rise_q, fall_q;

  clkdiv_mod_counter #(.MODULUS(DIV_N)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt)
  );

  assign rise_en = (cnt == '0);
  assign fall_en = (cnt == MID);

  clkdiv_edge_toggle #(.RISING(1'b1)) u_tog_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rise_en),
    .q_o    (rise_q)
  );

  clkdiv_edge_toggle #(.RISING(1'b0)) u_tog_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (fall_en),
    .q_o    (fall_q)
  );

  // quadrature toggles: only one input moves at a time
  assign clk_o = rise_q ^ fall_q;

  p_rise_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != '0) |=> $stable(rise_q));

  p_rise_flip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0) |=> (rise_q != $past(rise_q)));

  p_fall_hold_r7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (cnt != MID) |=> $stable(fall_q));

  p_fall_flip_r7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (cnt == MID) |=> (fall_q != $past(fall_q)));

endmodule

// File: tb/odd_clk_div_bench.sv
`timescale 1ns/1ps
module odd_clk_div_bench;

  localparam int HALF_NS = 2;   // 250 MHz
  localparam int EDGES   = 12;

  logic clk   = 1'b0;
  logic rst_n = 1'b0;
  int   checks   = 0;
  int   failures = 0;
  int   round    = 1;
  bit   done [3];

  always #HALF_NS clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d @%0t", req, what, act, exp, $time);
    end
  endtask

  for (genvar g = 0; g < 3; g++) begin : g_dut
    localparam int N = 3 + 2 * g;
    logic   clk_o;
    longint exp_t[$];
    bit     exp_v[$];
    bit     armed = 1'b0;
    bit     first = 1'b0;
    longint last_t, last_rise;

    odd_clk_div #(.DIV_N(N)) u_odd_clk_div (
      .clk_i  (clk),
      .rst_ni (rst_n),
      .clk_o  (clk_o)
    );

    // driver: predict edges from the release time (posedges at 4k+2 ns)
    task automatic plan(input longint trel);
      longint k, t0;
      k  = (trel - 2) / (2 * HALF_NS) + 1;
      t0 = k * (2 * HALF_NS) + 2;
      for (int i = 0; i < EDGES; i++) begin
        exp_t.push_back(t0 + longint'(i) * N * HALF_NS);
        exp_v.push_back(i % 2 == 0);
      end
    endtask

    initial forever begin
      @(posedge rst_n);
      plan($time);
      first = 1'b1;
      armed = 1'b1;
      wait (exp_t.size() == 0);
      armed = 1'b0;
      done[g] = 1'b1;
    end

    // monitor: pop and compare on every output change
    initial forever begin
      longint t, et;
      bit     ev;
      @(clk_o);
      if (rst_n && armed && exp_t.size() != 0) begin
        t  = $time;
        et = exp_t.pop_front();
        ev = exp_v.pop_front();
        chk(clk_o == ev, "R6", $sformatf("N=%0d edge level", N), clk_o, ev);
        chk(clk == clk_o, "R6", $sformatf("N=%0d edge on matching ref edge", N), clk, clk_o);
        if (first) begin
          chk(t == et, (round == 1) ? "R2" : "R8", $sformatf("N=%0d first rise time", N), t, et);
          first     = 1'b0;
          last_rise = t;
        end else begin
          chk(t == et, "R6", $sformatf("N=%0d edge time", N), t, et);
          if (clk_o == 1'b0) begin
            // high phase, also covers R7 falling-toggle match value
            chk(t - last_t == N * HALF_NS, "R4", $sformatf("N=%0d high width", N),
                t - last_t, N * HALF_NS);
          end else begin
            chk(t - last_t == N * HALF_NS, "R5", $sformatf("N=%0d low width", N),
                t - last_t, N * HALF_NS);
            chk(t - last_rise == 2 * N * HALF_NS, "R3", $sformatf("N=%0d period", N),
                t - last_rise, 2 * N * HALF_NS);
            last_rise = t;
          end
        end
        last_t = t;
      end
    end
  end

  task automatic chk_low(input string req);
    chk(g_dut[0].clk_o == 1'b0, req, "N=3 out in reset", g_dut[0].clk_o, 0);
    chk(g_dut[1].clk_o == 1'b0, req, "N=5 out in reset", g_dut[1].clk_o, 0);
    chk(g_dut[2].clk_o == 1'b0, req, "N=7 out in reset", g_dut[2].clk_o, 0);
  endtask

  initial begin
    #5;
    chk_low("R1");
    #6 rst_n = 1'b1;            // release at 11 ns, between edges
    wait (done[0] && done[1] && done[2]);
    #3;
    foreach (done[i]) done[i] = 1'b0;
    round = 2;
    rst_n = 1'b0;               // mid-run async reset, off edge
    #1;
    chk_low("R1");
    #8;
    chk_low("R8");
    rst_n = 1'b1;
    wait (done[0] && done[1] && done[2]);
    #5;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule